// File: doc/BRIEF.md
# Multiplexed ADC Conversion Sequencer

This block sequences single conversions of an eight-input analog converter for a host on a simple register bus. Software writes a 16-bit control word. That word picks the input, carries a ten-bit channel enable mask, can ask for a settling wait, and launches the conversion. The sequencer steers the external input multiplexer. It waits the settling time if one was requested. It then raises a request to the converter and holds it until the converter answers with a done pulse and a sample.

The sample lands in a result register. In the same clock edge a sticky completion flag sets in a status register. A host polling the status register must clear the flag by writing a one to it. An enable register with the flag at the same bit position gates a level interrupt output. The interrupt stays high until the flag is cleared or disabled.

Register addresses on the two-bit `regAddr` are: 0 control, 1 result, 2 status, 3 interrupt enable. Reads are combinational from `regAddr`. Writes take effect at the clock edge where `regWr` is high.

Top module: `adc_seq_top`

## Requirements
- R1: After reset `convReq` and `irq` are 0, `muxSel` is 0, and all four registers read 0.
- R2: A control word starts a conversion only when bit 0 is 1 and the sequencer is idle. In that case `muxSel` takes bits 3:1 as the channel. The control register then reads back bit 15 as the delay flag, bits 14:5 as the mask, bit 4 as 0, bits 3:1 as the channel and bit 0 as busy.
- R3: If control bit 15 is 0, `convReq` is high from the first edge after the accepted write. If bit 15 is 1, `convReq` rises exactly SETTLE_CYCLES edges after that write.
- R4: `convReq` stays high until the edge at which `convDone` is sampled high, and is low after that edge.
- R5: A control write with bit 0 clear, or any control write while busy, changes neither `muxSel`, the control readback nor the conversion in progress.
- R6: At the edge that samples `convDone`, `convData` is stored in the result register and status bit 2 (value 0x4) sets.
- R7: Status bit 2 is sticky. Writing the status register with bit 2 set clears it, and a status write with bit 2 clear leaves it unchanged. Other status bits read 0.
- R8: If a completion and a clearing status write fall on the same edge, status bit 2 stays set.
- R9: Enable register bit 2 is stored and read back, with other bits 0. `irq` equals status bit 2 AND enable bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data for `regAddr` |
| muxSel | output | 3 | Analog multiplexer select |
| convReq | output | 1 | Conversion request to the converter |
| convDone | input | 1 | Converter completion pulse |
| convData | input | 16 | Converter sample, valid with `convDone` |
| irq | output | 1 | Level interrupt |

## Verification
A wrong state in the sequencer shows at the ports almost at once. A miscounted settling timer moves the rising edge of `convReq`, and a stuck state leaves `convReq` high or never raises it. The bench measures the cycle count to that rise for every channel, with and without the delay. A corrupted flag or enable bit is visible on `irq` and on the status read in the same cycle. A lost configuration shows on `muxSel` and in the control readback before the converter is asked.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int REG_W     = 16;
  localparam int ADDR_W    = 2;
  localparam int CHAN_W    = 3;
  localparam int CHAN_LSB  = 1;
  localparam int MASK_W    = 10;
  localparam int MASK_LSB  = 5;
  localparam int DELAY_BIT = 15;
  localparam int START_BIT = 0;
  localparam int DONE_BIT  = 2;

  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_RESULT = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 2'd3;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SETTLE = 2'd1,
    ST_REQ    = 2'd2
  } seqState_t;

  typedef struct packed {
    logic loadCfg;
    logic capture;
  } seqStrobe_t;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int SETTLE_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWr,
  input  logic       startBit,
  input  logic       delayBit,
  input  logic       convDone,
  output seqStrobe_t strobe,
  output logic       busy,
  output logic       convReq
);
  localparam int CNT_W = (SETTLE_CYCLES > 1) ? $clog2(SETTLE_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(SETTLE_CYCLES - 1);

  seqState_t       state;
  logic [CNT_W-1:0] settleCnt;
  logic            startHit;

  assign startHit       = ctrlWr && startBit && (state == ST_IDLE);
  assign strobe.loadCfg = startHit;
  assign strobe.capture = (state == ST_REQ) && convDone;
  assign busy           = (state != ST_IDLE);
  assign convReq        = (state == ST_REQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      settleCnt <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startHit) begin
            settleCnt <= CNT_LOAD;
            state     <= delayBit ? ST_SETTLE : ST_REQ;
          end
        end
        ST_SETTLE: begin
          if (settleCnt == '0) state <= ST_REQ;
          else                 settleCnt <= settleCnt - 1'b1;
        end
        ST_REQ: begin
          if (convDone) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  a_r4_req_held: assert property (@(posedge clk) disable iff (!rstN)
    convReq && !convDone |=> convReq);
  a_r4_req_drops: assert property (@(posedge clk) disable iff (!rstN)
    convReq && convDone |=> !convReq);
  a_r3_no_delay_req: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr && startBit && !busy && !delayBit |=> convReq);
  a_r3_delay_waits: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr && startBit && !busy && delayBit |=> busy && !convReq);
  a_r5_busy_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    busy && !convReq && ctrlWr && startBit |=> busy);
endmodule

// File: rtl/adc_seq_dpath.sv
module adc_seq_dpath
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              busy,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0]  regWrData,
  input  logic [REG_W-1:0]  convData,
  output logic [REG_W-1:0]  regRdData,
  output logic [CHAN_W-1:0] muxSel,
  output logic              irq
);
  logic [CHAN_W-1:0] cfgChan;
  logic [MASK_W-1:0] cfgMask;
  logic              cfgDelay;
  logic [REG_W-1:0]  resultReg;
  logic              doneFlag;
  logic              irqEn;
  logic              clearHit;
  logic              enWr;

  assign clearHit = regWr && (regAddr == ADDR_STATUS) && regWrData[DONE_BIT];
  assign enWr     = regWr && (regAddr == ADDR_ENABLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgChan  <= '0;
      cfgMask  <= '0;
      cfgDelay <= 1'b0;
    end else if (strobe.loadCfg) begin
      cfgChan  <= regWrData[CHAN_LSB +: CHAN_W];
      cfgMask  <= regWrData[MASK_LSB +: MASK_W];
      cfgDelay <= regWrData[DELAY_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultReg <= '0;
    end else if (strobe.capture) begin
      resultReg <= convData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneFlag <= 1'b0;
      irqEn    <= 1'b0;
    end else begin
      if (strobe.capture)  doneFlag <= 1'b1;
      else if (clearHit)   doneFlag <= 1'b0;
      if (enWr)            irqEn <= regWrData[DONE_BIT];
    end
  end

  always_comb begin
    regRdData = '0;
    unique case (regAddr)
      ADDR_CTRL: begin
        regRdData[START_BIT]                = busy;
        regRdData[CHAN_LSB +: CHAN_W]       = cfgChan;
        regRdData[MASK_LSB +: MASK_W]       = cfgMask;
        regRdData[DELAY_BIT]                = cfgDelay;
      end
      ADDR_RESULT: regRdData = resultReg;
      ADDR_STATUS: regRdData[DONE_BIT] = doneFlag;
      ADDR_ENABLE: regRdData[DONE_BIT] = irqEn;
      default:     regRdData = '0;
    endcase
  end

  assign muxSel = cfgChan;
  assign irq    = doneFlag && irqEn;

  a_r6_done_on_capture: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> doneFlag);
  a_r6_result_on_capture: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> resultReg == $past(convData));
  a_r7_done_sticky: assert property (@(posedge clk) disable iff (!rstN)
    doneFlag && !clearHit |=> doneFlag);
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture && clearHit |=> doneFlag);
  a_r9_irq_fall_cause: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irq) |-> $past(clearHit || enWr));
  a_r5_cfg_frozen_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(cfgChan) && $stable(cfgMask) && $stable(cfgDelay));
endmodule

// File: rtl/adc_seq_top.sv
module adc_seq_top
  import adc_seq_pkg::*;
#(
  parameter int SETTLE_CYCLES = 64
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [1:0]  regAddr,
  input  logic [15:0] regWrData,
  output logic [15:0] regRdData,
  output logic [2:0]  muxSel,
  output logic        convReq,
  input  logic        convDone,
  input  logic [15:0] convData,
  output logic        irq
);
  seqStrobe_t strobe;
  logic       busy;
  logic       ctrlWr;

  assign ctrlWr = regWr && (regAddr == ADDR_CTRL);

  adc_seq_ctrl #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .ctrlWr   (ctrlWr),
    .startBit (regWrData[START_BIT]),
    .delayBit (regWrData[DELAY_BIT]),
    .convDone (convDone),
    .strobe   (strobe),
    .busy     (busy),
    .convReq  (convReq)
  );

  adc_seq_dpath u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busy      (busy),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regWrData (regWrData),
    .convData  (convData),
    .regRdData (regRdData),
    .muxSel    (muxSel),
    .irq       (irq)
  );
endmodule

// File: tb/adc_seq_top_tb.sv
`timescale 1ns/1ps
module adc_seq_top_tb;
  localparam int SETTLE = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [2:0]  muxSel;
  logic        convReq;
  logic        convDone = 1'b0;
  logic [15:0] convData = '0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  bit ended = 0;

  always #4 clk = ~clk;

  adc_seq_top #(.SETTLE_CYCLES(SETTLE)) u_dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .muxSel(muxSel),
    .convReq(convReq), .convDone(convDone), .convData(convData), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    regWr = 1'b1; regAddr = a; regWrData = d;
    @(posedge clk); #1;
    regWr = 1'b0; regWrData = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    regAddr = a; #0.5; v = regRdData;
  endtask

  function automatic logic [15:0] ctrlWord(input bit dly, input logic [9:0] mask,
                                           input logic [2:0] ch, input bit st);
    return {dly, mask, 1'b0, ch, st};
  endfunction

  task automatic doConv(input logic [2:0] ch, input bit dly, input logic [9:0] mask,
                        input int lat, input logic [15:0] val, input bit irqOn);
    logic [15:0] v;
    int n;
    wr(2'd0, ctrlWord(dly, mask, ch, 1'b1));
    chk("R2 muxSel", muxSel, ch);
    rd(2'd0, v);
    chk("R2 ctrl readback busy", v, ctrlWord(dly, mask, ch, 1'b1));
    n = 0;
    while (!convReq && n < 1000) begin
      @(posedge clk); #1; n++;
    end
    chk("R3 req latency", n, dly ? SETTLE : 0);
    repeat (lat) begin @(posedge clk); #1; end
    chk("R4 req held", convReq, 1'b1);
    convDone = 1'b1; convData = val;
    @(posedge clk); #1;
    convDone = 1'b0; convData = 16'hDEAD;
    chk("R4 req dropped", convReq, 1'b0);
    rd(2'd1, v);  chk("R6 result", v, val);
    rd(2'd2, v);  chk("R6 done set", v, 16'h0004);
    rd(2'd0, v);  chk("R2 ctrl idle readback", v, ctrlWord(dly, mask, ch, 1'b0));
    chk("R9 irq", irq, irqOn);
  endtask

  initial begin
    #(8 * 200000);
    if (!ended) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    repeat (4) @(posedge clk);
    #1 rstN = 1'b1;
    chk("R1 convReq", convReq, 0);
    chk("R1 irq", irq, 0);
    chk("R1 muxSel", muxSel, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v); chk("R1 reg", v, 0);
    end

    wr(2'd3, 16'hFFFF);
    rd(2'd3, v); chk("R9 enable readback", v, 16'h0004);

    for (int d = 0; d < 2; d++) begin
      for (int c = 0; c < 8; c++) begin
        logic [15:0] val;
        val = 16'(c * 16'h2111) ^ (d != 0 ? 16'h8001 : 16'h0);
        doConv(3'(c), d[0], 10'((c * 10'h55) ^ (d * 10'h3C3)), c + 1, val, 1'b1);
        wr(2'd2, 16'h0000);
        rd(2'd2, v); chk("R7 zero write no effect", v, 16'h0004);
        wr(2'd2, 16'h0004);
        rd(2'd2, v); chk("R7 w1c clears", v, 16'h0000);
        chk("R9 irq after clear", irq, 0);
      end
    end

    // R5: start bit clear while idle
    wr(2'd0, ctrlWord(1'b0, 10'h2AA, 3'd6, 1'b0));
    chk("R5 no req on start=0", convReq, 0);
    rd(2'd0, v); chk("R5 cfg kept on start=0", v, ctrlWord(1'b1, 10'((7 * 10'h55) ^ 10'h3C3), 3'd7, 1'b0));

    // R5: start while busy, then finish with R8 collision
    wr(2'd0, ctrlWord(1'b1, 10'h011, 3'd2, 1'b1));
    wr(2'd0, ctrlWord(1'b0, 10'h3FF, 3'd5, 1'b1));
    chk("R5 muxSel kept busy", muxSel, 3'd2);
    rd(2'd0, v); chk("R5 ctrl kept busy", v, ctrlWord(1'b1, 10'h011, 3'd2, 1'b1));
    repeat (SETTLE + 2) begin @(posedge clk); #1; end
    chk("R5 conversion continues", convReq, 1);
    convDone = 1'b1; convData = 16'h1357;
    @(posedge clk); #1; convDone = 1'b0;
    rd(2'd2, v); chk("R6 done before collision", v, 16'h0004);

    // R8: completion and clear on the same edge
    wr(2'd0, ctrlWord(1'b0, 10'h001, 3'd4, 1'b1));
    regWr = 1'b1; regAddr = 2'd2; regWrData = 16'h0004;
    convDone = 1'b1; convData = 16'hBEEF;
    @(posedge clk); #1;
    regWr = 1'b0; convDone = 1'b0;
    rd(2'd2, v); chk("R8 set wins over clear", v, 16'h0004);
    rd(2'd1, v); chk("R8 result", v, 16'hBEEF);

    // R9: enable gating
    wr(2'd3, 16'h0000);
    chk("R9 irq disabled", irq, 0);
    wr(2'd3, 16'h0004);
    chk("R9 irq enabled", irq, 1);
    wr(2'd3, 16'hFFFB);
    rd(2'd3, v); chk("R9 enable bit only", v, 16'h0000);
    chk("R9 irq off", irq, 0);

    ended = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule